// File: doc/BRIEF.md
# Way-Gated Set-Associative Tag Controller

This block is the tag and replacement controller of a write-back set-associative cache. By default all eight ways are active. At run time the active associativity can be cut to as few as two ways, which leaves a quarter of the capacity, so that the unused ways can be switched off. Each set is kept as one combined record that holds the valid bits, the dirty bits, the tags and the recency ages of every way. A lookup hits only in a way that is currently enabled. On a miss the block allocates a victim, chosen from the enabled ways only, and reports a write-back when that victim holds modified data.

A new way mask is applied through a reconfiguration sequence. The sequence visits every set in turn. Each dirty line in a way that is being switched off is written back, one line per cycle. The lines of those ways are then marked invalid. The new mask takes effect only after the last set has been visited. During the sequence the block refuses lookups and further configuration requests. Ways that are switched back on later come up empty.

Top module: `waygate_cache`

## Requirements
- R1: After reset every line is invalid, all ways are enabled (`way_gated` is all zero), `lk_ready` is 1, `cfg_busy` is 0, and neither `rsp_valid` nor `evict_valid` is asserted.
- R2: A lookup accepted in cycle N (`lk_valid` and `lk_ready` both high) gives `rsp_valid` in cycle N+1. If the tag (address bits above the set index) is held in an enabled valid way, `rsp_hit` is 1 and `rsp_way` is that way.
- R3: On a miss the line is allocated into the way reported on `rsp_victim`, so a later lookup of the same line hits in that way.
- R4: The victim is the lowest-numbered enabled way that is invalid. If every enabled way is valid, the victim is the enabled way that was used least recently. Both hits and fills count as uses.
- R5: A lookup with `lk_wr` high marks the line dirty. When a miss picks a valid dirty victim, `evict_valid` is 1 in the response cycle, `evict_way` equals the victim, and `evict_addr` is {victim tag, set index, zero offset}. A clean or invalid victim raises no eviction.
- R6: A configuration request yields the effective mask `cfg_ways` OR'd with the lowest MIN_WAYS ways. Once the sequence ends, `way_gated` equals the inverse of the effective mask, and it does not change outside a sequence.
- R7: During reconfiguration, `cfg_busy` stays high for exactly NUM_SETS cycles plus one cycle per dirty line in a disabled way. Those lines are written back through `evict_addr` in ascending set order, and in ascending way order within a set. Lookups are not accepted while `cfg_busy` is high.
- R8: A disabled way never produces a hit and is never chosen as a victim.
- R9: A way that is disabled and later re-enabled holds no valid lines, so a line it held before it was disabled misses.
- R10: A lookup presented in the same cycle as an accepted configuration request completes with the old mask. The new mask follows after the sequence.
- R11: A configuration request made while `cfg_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_wr | input | 1 | Lookup is a store (marks line dirty) |
| lk_ready | output | 1 | Lookups are accepted this cycle |
| cfg_wr | input | 1 | Way-enable configuration write |
| cfg_ways | input | NUM_WAYS | Requested way-enable mask |
| cfg_busy | output | 1 | Reconfiguration sequence in progress |
| way_gated | output | NUM_WAYS | Ways currently power-gated |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | log2(NUM_WAYS) | Way that hit |
| rsp_victim | output | log2(NUM_WAYS) | Way allocated on a miss |
| evict_valid | output | 1 | Dirty line write-back request |
| evict_way | output | log2(NUM_WAYS) | Way of the written-back line |
| evict_addr | output | ADDR_W | Line address of the written-back line |

## Verification
The lookup path and the reconfiguration sequence can meet in a single cycle. The bench provokes this by raising `lk_valid` and `cfg_wr` on the same edge. The response must then be judged against the old mask, including any write-back the lookup itself causes. The flush write-backs that follow, and the final gated mask, must reflect the state the lookup left behind. One cycle into the sequence the bench also drives a stray lookup and a stray mask. No response may appear for the stray lookup, and the final gating must match the first request only.

// File: rtl/waygate_pkg.sv
package waygate_pkg;

  typedef enum logic [0:0] {
    CTL_IDLE  = 1'b0,
    CTL_FLUSH = 1'b1
  } ctl_state_e;

  // index of the lowest set bit, zero when none is set
  function automatic int unsigned lowest_one(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = unsigned'(i);
    end
    return r;
  endfunction

  // force the lowest 'keep' ways on
  function automatic logic [31:0] floor_mask(input logic [31:0] req, input int unsigned keep);
    return req | ((32'd1 << keep) - 32'd1);
  endfunction

endpackage

// File: rtl/waygate_tag_match.sv
module waygate_tag_match #(
  parameter  int NUM_WAYS = 8,
  parameter  int TAG_W    = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [NUM_WAYS-1:0]            way_vld,
  input  logic [NUM_WAYS-1:0]            way_en,
  input  logic [TAG_W-1:0]               probe_tag,
  output logic                           hit,
  output logic [WAY_W-1:0]               hit_way
);
  logic [NUM_WAYS-1:0] hit_vec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_vld[w] & way_en[w] & (way_tag[w] == probe_tag);
  end

  assign hit     = |hit_vec;
  assign hit_way = WAY_W'(waygate_pkg::lowest_one(32'(hit_vec)));
endmodule

// File: rtl/waygate_victim_pick.sv
module waygate_victim_pick #(
  parameter  int NUM_WAYS = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] way_age,
  input  logic [NUM_WAYS-1:0]            way_vld,
  input  logic [NUM_WAYS-1:0]            way_en,
  output logic [WAY_W-1:0]               victim
);
  logic [NUM_WAYS-1:0] free_ways;
  logic [WAY_W-1:0]    old_way;
  logic [WAY_W-1:0]    old_age;

  assign free_ways = way_en & ~way_vld;

  // ages form a permutation, so the oldest enabled way is unique
  always_comb begin
    old_way = '0;
    old_age = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (way_en[w] && (way_age[w] >= old_age)) begin
        old_way = WAY_W'(w);
        old_age = way_age[w];
      end
    end
  end

  assign victim = (|free_ways) ? WAY_W'(waygate_pkg::lowest_one(32'(free_ways))) : old_way;
endmodule

// File: rtl/waygate_reconfig.sv
module waygate_reconfig
  import waygate_pkg::*;
#(
  parameter  int NUM_WAYS = 8,
  parameter  int MIN_WAYS = 2,
  parameter  int NUM_SETS = 16,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [NUM_WAYS-1:0] cfg_ways,
  input  logic [NUM_WAYS-1:0] set_vld,
  input  logic [NUM_WAYS-1:0] set_dty,
  output logic                busy,
  output logic [SET_W-1:0]    scan_set,
  output logic [NUM_WAYS-1:0] en_mask,
  output logic [NUM_WAYS-1:0] drop_mask,
  output logic                fl_evict,
  output logic [WAY_W-1:0]    fl_way,
  output logic                fl_clear
);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  ctl_state_e          st_q;
  logic [SET_W-1:0]    scan_q;
  logic [NUM_WAYS-1:0] tgt_q;
  logic [NUM_WAYS-1:0] en_q;
  logic [NUM_WAYS-1:0] pend;

  assign busy      = (st_q == CTL_FLUSH);
  assign scan_set  = scan_q;
  assign en_mask   = en_q;
  assign drop_mask = en_q & ~tgt_q;
  assign pend      = set_vld & set_dty & drop_mask;
  assign fl_evict  = busy & (|pend);
  assign fl_way    = WAY_W'(lowest_one(32'(pend)));
  assign fl_clear  = busy & ~(|pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CTL_IDLE;
      scan_q <= '0;
      tgt_q  <= '1;
      en_q   <= '1;
    end else begin
      case (st_q)
        CTL_IDLE: begin
          if (cfg_wr) begin
            tgt_q  <= NUM_WAYS'(floor_mask(32'(cfg_ways), unsigned'(MIN_WAYS)));
            scan_q <= '0;
            st_q   <= CTL_FLUSH;
          end
        end
        default: begin
          if (fl_clear) begin
            if (scan_q == LAST_SET) begin
              en_q <= tgt_q;
              st_q <= CTL_IDLE;
            end else begin
              scan_q <= scan_q + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/waygate_cache.sv
module waygate_cache
  import waygate_pkg::*;
#(
  parameter  int NUM_WAYS = 8,
  parameter  int MIN_WAYS = 2,
  parameter  int NUM_SETS = 16,
  parameter  int ADDR_W   = 16,
  parameter  int OFF_W    = 4,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int TAG_W    = ADDR_W - SET_W - OFF_W,
  localparam int WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [ADDR_W-1:0]   lk_addr,
  input  logic                lk_wr,
  output logic                lk_ready,
  input  logic                cfg_wr,
  input  logic [NUM_WAYS-1:0] cfg_ways,
  output logic                cfg_busy,
  output logic [NUM_WAYS-1:0] way_gated,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [WAY_W-1:0]    rsp_way,
  output logic [WAY_W-1:0]    rsp_victim,
  output logic                evict_valid,
  output logic [WAY_W-1:0]    evict_way,
  output logic [ADDR_W-1:0]   evict_addr
);
  typedef logic [NUM_WAYS-1:0][WAY_W-1:0] age_vec_t;

  // one combined record per set: state, tags and recency
  typedef struct packed {
    logic [NUM_WAYS-1:0]            vld;
    logic [NUM_WAYS-1:0]            dty;
    logic [NUM_WAYS-1:0][TAG_W-1:0] tag;
    age_vec_t                       age;
  } set_entry_t;

  function automatic age_vec_t age_touch(input age_vec_t a, input logic [WAY_W-1:0] w);
    age_vec_t r;
    for (int i = 0; i < NUM_WAYS; i++) begin
      r[i] = (a[i] < a[w]) ? a[i] + 1'b1 : a[i];
    end
    r[w] = '0;
    return r;
  endfunction

  function automatic set_entry_t entry_init();
    set_entry_t e;
    e.vld = '0;
    e.dty = '0;
    e.tag = '0;
    for (int i = 0; i < NUM_WAYS; i++) e.age[i] = WAY_W'(i);
    return e;
  endfunction

  set_entry_t          arr_q [NUM_SETS];
  set_entry_t          cur;
  logic                busy;
  logic [SET_W-1:0]    scan_set;
  logic [SET_W-1:0]    lk_set;
  logic [SET_W-1:0]    rd_set;
  logic [TAG_W-1:0]    lk_tag;
  logic [NUM_WAYS-1:0] en_mask;
  logic [NUM_WAYS-1:0] drop_mask;
  logic                fl_evict;
  logic                fl_clear;
  logic [WAY_W-1:0]    fl_way;
  logic                hit;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    vic_way;
  logic [WAY_W-1:0]    ev_way;
  logic                lk_go;
  logic                miss_dirty;
  logic                lk_off_unused;

  assign lk_off_unused = ^lk_addr[OFF_W-1:0];
  assign lk_set        = lk_addr[OFF_W +: SET_W];
  assign lk_tag        = lk_addr[ADDR_W-1 -: TAG_W];
  assign rd_set        = busy ? scan_set : lk_set;
  assign cur           = arr_q[rd_set];
  assign lk_ready      = ~busy;
  assign lk_go         = lk_valid & ~busy;
  assign cfg_busy      = busy;
  assign way_gated     = ~en_mask;

  waygate_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
    .way_tag   (cur.tag),
    .way_vld   (cur.vld),
    .way_en    (en_mask),
    .probe_tag (lk_tag),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  waygate_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .way_age (cur.age),
    .way_vld (cur.vld),
    .way_en  (en_mask),
    .victim  (vic_way)
  );

  waygate_reconfig #(.NUM_WAYS(NUM_WAYS), .MIN_WAYS(MIN_WAYS), .NUM_SETS(NUM_SETS)) u_reconf (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_ways  (cfg_ways),
    .set_vld   (cur.vld),
    .set_dty   (cur.dty),
    .busy      (busy),
    .scan_set  (scan_set),
    .en_mask   (en_mask),
    .drop_mask (drop_mask),
    .fl_evict  (fl_evict),
    .fl_way    (fl_way),
    .fl_clear  (fl_clear)
  );

  assign miss_dirty = lk_go & ~hit & cur.vld[vic_way] & cur.dty[vic_way];
  assign ev_way     = lk_go ? vic_way : fl_way;

  // state array update: lookups only when idle, flush steps only when busy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) arr_q[s] <= entry_init();
    end else if (lk_go) begin
      if (hit) begin
        arr_q[lk_set].age <= age_touch(cur.age, hit_way);
        if (lk_wr) arr_q[lk_set].dty[hit_way] <= 1'b1;
      end else begin
        arr_q[lk_set].age          <= age_touch(cur.age, vic_way);
        arr_q[lk_set].vld[vic_way] <= 1'b1;
        arr_q[lk_set].dty[vic_way] <= lk_wr;
        arr_q[lk_set].tag[vic_way] <= lk_tag;
      end
    end else if (fl_evict) begin
      arr_q[scan_set].vld[fl_way] <= 1'b0;
      arr_q[scan_set].dty[fl_way] <= 1'b0;
    end else if (fl_clear) begin
      arr_q[scan_set].vld <= cur.vld & ~drop_mask;
      arr_q[scan_set].dty <= cur.dty & ~drop_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_way     <= '0;
      rsp_victim  <= '0;
      evict_valid <= 1'b0;
      evict_way   <= '0;
      evict_addr  <= '0;
    end else begin
      rsp_valid   <= lk_go;
      rsp_hit     <= lk_go & hit;
      rsp_way     <= hit_way;
      rsp_victim  <= vic_way;
      evict_valid <= miss_dirty | fl_evict;
      evict_way   <= ev_way;
      evict_addr  <= {cur.tag[ev_way], rd_set, {OFF_W{1'b0}}};
    end
  end
endmodule

// File: rtl/waygate_cache_chk.sv
module waygate_cache_chk #(
  parameter  int NUM_WAYS = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lk_valid,
  input logic                lk_ready,
  input logic                cfg_busy,
  input logic [NUM_WAYS-1:0] way_gated,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic [WAY_W-1:0]    rsp_way,
  input logic [WAY_W-1:0]    rsp_victim,
  input logic                evict_valid
);
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !way_gated[rsp_way]);                        // R8

  AST_VICTIM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> !way_gated[rsp_victim]);                    // R8

  AST_RSP_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid && lk_ready));                             // R2

  AST_EVICT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> ((rsp_valid && !rsp_hit) || cfg_busy));                 // R7

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_busy |-> !lk_ready);                                                // R7

  AST_GATE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_busy && !$past(cfg_busy)) |-> $stable(way_gated));                // R6
endmodule

bind waygate_cache waygate_cache_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_ready    (lk_ready),
  .cfg_busy    (cfg_busy),
  .way_gated   (way_gated),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_way     (rsp_way),
  .rsp_victim  (rsp_victim),
  .evict_valid (evict_valid)
);

// File: tb/waygate_cache_tb.sv
module waygate_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8, MINW = 2, NS = 16, AW = 16, OW = 4;
  localparam int SW = 4, TW = 8, WW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_wr = 1'b0;
  logic lk_ready;
  logic cfg_wr = 1'b0;
  logic [NW-1:0] cfg_ways = '0;
  logic cfg_busy;
  logic [NW-1:0] way_gated;
  logic rsp_valid, rsp_hit, evict_valid;
  logic [WW-1:0] rsp_way, rsp_victim, evict_way;
  logic [AW-1:0] evict_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  waygate_cache #(.NUM_WAYS(NW), .MIN_WAYS(MINW), .NUM_SETS(NS), .ADDR_W(AW), .OFF_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_wr(lk_wr),
    .lk_ready(lk_ready), .cfg_wr(cfg_wr), .cfg_ways(cfg_ways), .cfg_busy(cfg_busy),
    .way_gated(way_gated), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_victim(rsp_victim), .evict_valid(evict_valid), .evict_way(evict_way),
    .evict_addr(evict_addr)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference state: recency kept as global timestamps
  bit m_vld [NS][NW];
  bit m_dty [NS][NW];
  int m_tag [NS][NW];
  int m_stamp [NS][NW];
  int stamp = 0;
  logic [NW-1:0] m_en = '1;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic model_lookup(input logic [AW-1:0] a, input bit wr, output bit eh, output int ew,
                              output bit eev, output logic [AW-1:0] eaddr);
    int s;
    int t;
    int best;
    s = int'(a[OW +: SW]);
    t = int'(a[AW-1 -: TW]);
    eh = 0; ew = 0; eev = 0; eaddr = '0;
    for (int w = 0; w < NW; w++)
      if (m_en[w] && m_vld[s][w] && m_tag[s][w] == t) begin eh = 1; ew = w; end
    if (!eh) begin
      best = -1;
      for (int w = 0; w < NW; w++)
        if (m_en[w] && !m_vld[s][w] && best < 0) best = w;
      if (best < 0)
        for (int w = 0; w < NW; w++)
          if (m_en[w] && (best < 0 || m_stamp[s][w] < m_stamp[s][best])) best = w;
      ew = best;
      eev = m_vld[s][ew] && m_dty[s][ew];
      eaddr = {TW'(m_tag[s][ew]), SW'(s), OW'(0)};
    end
    stamp++;
    m_stamp[s][ew] = stamp;
    if (eh) begin
      if (wr) m_dty[s][ew] = 1;
    end else begin
      m_vld[s][ew] = 1; m_dty[s][ew] = wr; m_tag[s][ew] = t;
    end
  endtask

  task automatic check_rsp(input string lbl, input bit eh, input int ew, input bit eev, input logic [AW-1:0] eaddr);
    chk(rsp_valid == 1'b1, {lbl, " response valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_hit == eh, {lbl, " hit flag"}, 32'(rsp_hit), 32'(eh));
    if (eh) chk(rsp_way == WW'(ew), {lbl, " hit way"}, 32'(rsp_way), 32'(ew));
    else    chk(rsp_victim == WW'(ew), {lbl, " victim way"}, 32'(rsp_victim), 32'(ew));
    chk(evict_valid == eev, {lbl, " R5 eviction flag"}, 32'(evict_valid), 32'(eev));
    if (eev) begin
      chk(evict_addr == eaddr, {lbl, " R5 eviction address"}, 32'(evict_addr), 32'(eaddr));
      chk(evict_way == WW'(ew), {lbl, " R5 eviction way"}, 32'(evict_way), 32'(ew));
    end
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, input bit wr, input string lbl);
    bit eh, eev;
    int ew;
    logic [AW-1:0] eaddr;
    model_lookup(a, wr, eh, ew, eev, eaddr);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_wr = wr;
    @(negedge clk);
    lk_valid = 1'b0; lk_wr = 1'b0;
    check_rsp(lbl, eh, ew, eev, eaddr);
  endtask

  task automatic do_cfg(input logic [NW-1:0] mask, input bit with_lk, input logic [AW-1:0] a, input string lbl);
    logic [NW-1:0] eff, drop;
    logic [AW-1:0] ev_list [$];
    bit eh, eev;
    int ew, cnt, idx;
    logic [AW-1:0] eaddr;
    if (with_lk) model_lookup(a, 1'b0, eh, ew, eev, eaddr);
    eff  = mask | NW'((1 << MINW) - 1);
    drop = m_en & ~eff;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        if (drop[w] && m_vld[s][w] && m_dty[s][w])
          ev_list.push_back({TW'(m_tag[s][w]), SW'(s), OW'(0)});
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ways = mask;
    if (with_lk) begin lk_valid = 1'b1; lk_addr = a; lk_wr = 1'b0; end
    @(negedge clk);
    cfg_wr = 1'b0; lk_valid = 1'b0;
    if (with_lk) check_rsp({lbl, " R10 same-cycle lookup uses old mask"}, eh, ew, eev, eaddr);
    cnt = 0; idx = 0;
    while (cfg_busy && cnt < 2000) begin
      if (cnt >= 1) chk(rsp_valid == 1'b0, {lbl, " R7 lookup ignored while busy"}, 32'(rsp_valid), 32'd0);
      if (evict_valid && !(with_lk && cnt == 0)) begin
        if (idx < ev_list.size())
          chk(evict_addr == ev_list[idx], {lbl, " R7 flush write-back order"}, 32'(evict_addr), 32'(ev_list[idx]));
        else
          chk(1'b0, {lbl, " R7 extra flush write-back"}, 32'(evict_addr), 32'd0);
        idx++;
      end
      if (cnt == 1) begin
        lk_valid = 1'b1; lk_addr = a ^ 16'h8000; cfg_wr = 1'b1; cfg_ways = ~mask;
      end else begin
        lk_valid = 1'b0; cfg_wr = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    lk_valid = 1'b0; cfg_wr = 1'b0;
    chk(rsp_valid == 1'b0, {lbl, " R7 no late response"}, 32'(rsp_valid), 32'd0);
    chk(idx == ev_list.size(), {lbl, " R7 write-back count"}, 32'(idx), 32'(ev_list.size()));
    chk(cnt == NS + ev_list.size(), {lbl, " R7 busy length"}, 32'(cnt), 32'(NS + ev_list.size()));
    chk(way_gated == ~eff, {lbl, " R6 R11 gated mask"}, 32'(way_gated), 32'(~eff));
    m_en = eff;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++)
        if (drop[w]) begin m_vld[s][w] = 0; m_dty[s][w] = 0; end
  endtask

  task automatic sweep(input int n, inout int seed);
    logic [AW-1:0] a;
    for (int i = 0; i < n; i++) begin
      seed = seed * 1103515245 + 12345;
      a = {TW'(((seed >>> 16) & 32'h7fff) % 12), SW'((seed >>> 8) & 15), OW'(seed & 15)};
      do_lookup(a, seed[20], "R2/R3/R4/R8 sweep");
    end
  endtask

  initial begin
    int seed;
    seed = 7;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_vld[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(lk_ready == 1'b1, "R1 ready after reset", 32'(lk_ready), 32'd1);
    chk(cfg_busy == 1'b0, "R1 not busy after reset", 32'(cfg_busy), 32'd0);
    chk(way_gated == '0, "R1 no ways gated", 32'(way_gated), 32'd0);
    chk(rsp_valid == 1'b0, "R1 no response", 32'(rsp_valid), 32'd0);
    chk(evict_valid == 1'b0, "R1 no eviction", 32'(evict_valid), 32'd0);

    for (int i = 0; i < NW; i++) do_lookup({TW'(i), 4'd1, 4'd0}, 1'b1, "R3 R4 fill free ways");
    do_lookup({8'd3, 4'd1, 4'h5}, 1'b0, "R2 hit");
    do_lookup({8'd8, 4'd1, 4'd0}, 1'b0, "R4 R5 LRU dirty victim");
    do_lookup({8'd8, 4'd1, 4'd2}, 1'b0, "R3 refill hits");
    do_cfg(8'h03, 1'b0, 16'h0000, "shrink to two ways");
    do_lookup({8'd1, 4'd1, 4'd0}, 1'b0, "R2 R8 kept line");
    do_lookup({8'd5, 4'd1, 4'd0}, 1'b0, "R8 disabled way misses");
    do_cfg(8'hFF, 1'b1, {8'd2, 4'd1, 4'd0}, "grow with lookup");
    do_lookup({8'd6, 4'd1, 4'd0}, 1'b0, "R9 re-enabled way lost");

    sweep(150, seed);
    do_cfg(8'h0F, 1'b0, 16'h0000, "mask 0F");
    sweep(150, seed);
    do_cfg(8'hF0, 1'b1, 16'h0230, "mask F0");
    sweep(150, seed);
    do_cfg(8'h5A, 1'b0, 16'h0000, "mask 5A");
    sweep(150, seed);
    do_cfg(8'h00, 1'b1, 16'h0470, "mask 00");
    sweep(150, seed);
    do_cfg(8'hFF, 1'b0, 16'h0000, "mask FF");
    sweep(150, seed);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule